// File: doc/BRIEF.md
# Baseband Register Access Controller

This controller carries out one register transaction at a time between a host and an external baseband device. The host presents a command: a register number, a data byte, a direction flag, a transfer-mode bit and a strobe-length bit. It pulses `cmd_valid` while the controller is idle. The controller raises `busy` and runs the transaction on one of two pin groups. The first is a serial group with clock, data out, data in and a frame enable. The second is a parallel group with an address bus, a write-data bus, a read-data bus, a direction line and a strobe.

The controller has three states. `ST_IDLE` waits for a command. `ST_SERIAL` shifts a frame. `ST_PARALLEL` holds the strobe.

- The transition from idle to serial or parallel is taken when `cmd_valid` is high in `ST_IDLE`. The mode bit chooses which.
- The transition from serial back to idle is taken at the end of the second half of the last frame bit.
- The transition from parallel back to idle is taken in the last strobe cycle.

A read updates `value` when the transaction finishes. A write loads the command data into `value` when the command is accepted.

Top module: `bbx_reg_access`

## Requirements
- R1: While reset is held and after its release, `busy`, `ser_en`, `ser_clk`, `ser_dout` and `par_strobe` are 0, `par_rd`, `par_addr` and `par_wdata` are 0, and `value` is 0.
- R2: A command is accepted on a clock edge where `cmd_valid` is 1 and the controller is idle. `busy` is 1 from the next cycle, and `value` takes `cmd_data` at that edge.
- R3: While `busy` is 1, `cmd_valid` is ignored. The running transaction, every output and `value` are unaffected until the transaction finishes.
- R4: `cmd_par` = 0 selects a serial transaction and `cmd_par` = 1 selects a parallel one. The pin group that is not selected stays at 0 for the whole transaction.
- R5: In a parallel transaction, `par_strobe` is 1 for exactly STROBE_SHORT cycles when `cmd_long` = 0 and exactly STROBE_LONG cycles when `cmd_long` = 1. `busy` is 1 for the same cycles. `par_addr` and `par_wdata` carry the command's register number and data only while the strobe is 1, and are 0 otherwise.
- R6: A parallel read loads `par_rdata`, as seen in the last strobe cycle, into `value`.
- R7: A serial frame has 1+AW+DW bits sent MSB first. The direction bit comes first, then the register number, then the data byte.
  - Each bit lasts 2*SCLK_HALF cycles, with `ser_clk` at 0 for the first SCLK_HALF cycles and at 1 for the rest.
  - `ser_en` is 1 on every frame cycle, and `busy` is 1 for exactly that many cycles.
- R8: In a serial read, `ser_dout` is 0 during the data bits. `ser_din` is sampled in the first high cycle of `ser_clk` of each data bit, MSB first. The byte collected this way is in `value` after the frame.
- R9: `busy` falls in the cycle after the last strobe cycle or frame cycle. If a command is waiting, it is accepted at the very next edge, leaving exactly one idle cycle between transactions.
- R10: The direction encoding is `cmd_read` = 0 for write and 1 for read. It appears as the first serial bit and on `par_rd` while the strobe is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_reg | input | AW | Register number |
| cmd_data | input | DW | Data byte for a write |
| cmd_read | input | 1 | Direction: 0 write, 1 read |
| cmd_par | input | 1 | Mode: 0 serial, 1 parallel |
| cmd_long | input | 1 | Strobe length: 0 short, 1 long |
| busy | output | 1 | Transaction in progress |
| value | output | DW | Written byte or returned byte |
| ser_clk | output | 1 | Serial clock |
| ser_dout | output | 1 | Serial data to the device |
| ser_en | output | 1 | Serial frame enable, active high |
| ser_din | input | 1 | Serial data from the device |
| par_strobe | output | 1 | Parallel strobe |
| par_rd | output | 1 | Parallel direction during the strobe |
| par_addr | output | AW | Parallel register number |
| par_wdata | output | DW | Parallel write data |
| par_rdata | input | DW | Parallel read data |

## Verification
The bench builds the controller with SCLK_HALF = 2, STROBE_SHORT = 4 and STROBE_LONG = 8, and 8-bit register and data fields. A half period longer than one cycle separates the sample point from the end of the bit, so a capture taken at the wrong phase shows up in `value`. Both strobe lengths produce distinct `busy` windows. A new command is kept pending across the end of a transaction, which reaches the one-idle-cycle turnaround. Commands issued while `busy` is high are checked for having no effect.

// File: rtl/bbx_pkg.sv
package bbx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SERIAL   = 2'd1,
        ST_PARALLEL = 2'd2
    } bbx_state_t;
endpackage

// File: rtl/bbx_phase_ctr.sv
// Divides each serial bit into a low half and a high half.
module bbx_phase_ctr #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk_hi,
    output logic sample_pt,
    output logic bit_end
);
    localparam int PERIOD = 2 * HALF;
    localparam int PW     = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [PW-1:0] phc_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phc_q <= '0;
        end else if (phc_q == PW'(PERIOD - 1)) begin
            phc_q <= '0;
        end else begin
            phc_q <= phc_q + 1'b1;
        end
    end

    assign sclk_hi   = run && (phc_q >= PW'(HALF));
    assign sample_pt = run && (phc_q == PW'(HALF));
    assign bit_end   = run && (phc_q == PW'(PERIOD - 1));
endmodule

// File: rtl/bbx_frame_shift.sv
// Outgoing frame register plus incoming byte collector.
module bbx_frame_shift #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [AW+DW:0]      load_word,
    input  logic                shift,
    input  logic                cap_en,
    input  logic                din,
    output logic                msb,
    output logic [DW-1:0]       cap_nxt
);
    localparam int FW = 1 + AW + DW;

    logic [FW-1:0] frame_q;
    logic [DW-1:0] cap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
            cap_q   <= '0;
        end else if (load) begin
            frame_q <= load_word;
            cap_q   <= '0;
        end else begin
            if (shift) begin
                frame_q <= {frame_q[FW-2:0], 1'b0};
            end
            if (cap_en) begin
                cap_q <= cap_nxt;
            end
        end
    end

    assign msb     = frame_q[FW-1];
    assign cap_nxt = cap_en ? {cap_q[DW-2:0], din} : cap_q;
endmodule

// File: rtl/bbx_strobe_ctr.sv
// Counts strobe cycles and flags the last one for the chosen length.
module bbx_strobe_ctr #(
    parameter int STROBE_SHORT = 4,
    parameter int STROBE_LONG  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic long_sel,
    output logic last
);
    localparam int CW = (STROBE_LONG > 1) ? $clog2(STROBE_LONG) : 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    assign limit = long_sel ? CW'(STROBE_LONG - 1) : CW'(STROBE_SHORT - 1);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = run && (cnt_q == limit);
endmodule

// File: rtl/bbx_reg_access.sv
module bbx_reg_access
    import bbx_pkg::*;
#(
    parameter int AW           = 8,
    parameter int DW           = 8,
    parameter int SCLK_HALF    = 2,
    parameter int STROBE_SHORT = 4,
    parameter int STROBE_LONG  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [AW-1:0] cmd_reg,
    input  logic [DW-1:0] cmd_data,
    input  logic          cmd_read,
    input  logic          cmd_par,
    input  logic          cmd_long,
    output logic          busy,
    output logic [DW-1:0] value,
    output logic          ser_clk,
    output logic          ser_dout,
    output logic          ser_en,
    input  logic          ser_din,
    output logic          par_strobe,
    output logic          par_rd,
    output logic [AW-1:0] par_addr,
    output logic [DW-1:0] par_wdata,
    input  logic [DW-1:0] par_rdata
);
    localparam int FRAME_BITS = 1 + AW + DW;
    localparam int BIW        = $clog2(FRAME_BITS);
    localparam logic [BIW-1:0] LAST_BIT   = BIW'(FRAME_BITS - 1);
    localparam logic [BIW-1:0] FIRST_DATA = BIW'(AW + 1);

    bbx_state_t    state_q, state_d;
    logic          op_read_q, op_long_q;
    logic [AW-1:0] op_reg_q;
    logic [DW-1:0] op_data_q, value_q;
    logic [BIW-1:0] bit_q;

    logic          accept, ser_run, par_run, in_data;
    logic          sclk_hi, sample_pt, bit_end;
    logic          shift_msb, cap_en, strobe_last, ser_done, par_done;
    logic [DW-1:0] cap_nxt;

    assign accept   = (state_q == ST_IDLE) && cmd_valid;
    assign ser_run  = (state_q == ST_SERIAL);
    assign par_run  = (state_q == ST_PARALLEL);
    assign in_data  = (bit_q >= FIRST_DATA);
    assign cap_en   = ser_run && op_read_q && in_data && sample_pt;
    assign ser_done = ser_run && bit_end && (bit_q == LAST_BIT);
    assign par_done = par_run && strobe_last;

    bbx_phase_ctr #(.HALF(SCLK_HALF)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (ser_run),
        .sclk_hi   (sclk_hi),
        .sample_pt (sample_pt),
        .bit_end   (bit_end)
    );

    bbx_frame_shift #(.AW(AW), .DW(DW)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_word ({cmd_read, cmd_reg, cmd_data}),
        .shift     (ser_run && bit_end),
        .cap_en    (cap_en),
        .din       (ser_din),
        .msb       (shift_msb),
        .cap_nxt   (cap_nxt)
    );

    bbx_strobe_ctr #(.STROBE_SHORT(STROBE_SHORT), .STROBE_LONG(STROBE_LONG)) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (par_run),
        .long_sel (op_long_q),
        .last     (strobe_last)
    );

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = cmd_par ? ST_PARALLEL : ST_SERIAL;
                end
            end
            ST_SERIAL: begin
                if (ser_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_PARALLEL: begin
                if (par_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Command latch, bit index and result byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_read_q <= 1'b0;
            op_long_q <= 1'b0;
            op_reg_q  <= '0;
            op_data_q <= '0;
            value_q   <= '0;
            bit_q     <= '0;
        end else if (accept) begin
            op_read_q <= cmd_read;
            op_long_q <= cmd_long;
            op_reg_q  <= cmd_reg;
            op_data_q <= cmd_data;
            value_q   <= cmd_data;
            bit_q     <= '0;
        end else begin
            if (ser_run && bit_end && !ser_done) begin
                bit_q <= bit_q + 1'b1;
            end
            if (ser_done && op_read_q) begin
                value_q <= cap_nxt;
            end
            if (par_done && op_read_q) begin
                value_q <= par_rdata;
            end
        end
    end

    // Pin drive per state
    always_comb begin
        busy       = 1'b0;
        ser_clk    = 1'b0;
        ser_dout   = 1'b0;
        ser_en     = 1'b0;
        par_strobe = 1'b0;
        par_rd     = 1'b0;
        par_addr   = '0;
        par_wdata  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SERIAL: begin
                busy     = 1'b1;
                ser_en   = 1'b1;
                ser_clk  = sclk_hi;
                ser_dout = (op_read_q && in_data) ? 1'b0 : shift_msb;
            end
            ST_PARALLEL: begin
                busy       = 1'b1;
                par_strobe = 1'b1;
                par_rd     = op_read_q;
                par_addr   = op_reg_q;
                par_wdata  = op_data_q;
            end
            default: ;
        endcase
    end

    assign value = value_q;
endmodule

// File: rtl/bbx_reg_access_chk.sv
module bbx_reg_access_chk #(
    parameter int DW           = 8,
    parameter int STROBE_SHORT = 4,
    parameter int STROBE_LONG  = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          busy,
    input logic [DW-1:0] value,
    input logic          ser_clk,
    input logic          ser_en,
    input logic          par_strobe
);
    logic [15:0] run_len_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !par_strobe) begin
            run_len_q <= '0;
        end else begin
            run_len_q <= run_len_q + 1'b1;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ser_en && !par_strobe && !ser_clk));

    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid) |=> busy);

    p_value_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(value));

    p_one_group_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ser_en && par_strobe));

    p_strobe_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(par_strobe) |-> (run_len_q == 16'(STROBE_SHORT) || run_len_q == 16'(STROBE_LONG)));

    p_clk_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> ser_en);
endmodule

bind bbx_reg_access bbx_reg_access_chk #(
    .DW           (DW),
    .STROBE_SHORT (STROBE_SHORT),
    .STROBE_LONG  (STROBE_LONG)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .busy       (busy),
    .value      (value),
    .ser_clk    (ser_clk),
    .ser_en     (ser_en),
    .par_strobe (par_strobe)
);

// File: tb/bbx_reg_access_bench.sv
module bbx_reg_access_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int H  = 2;
    localparam int SS = 4;
    localparam int SL = 8;
    localparam int FRAME = 1 + AW + DW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [AW-1:0] cmd_reg = '0;
    logic [DW-1:0] cmd_data = '0;
    logic cmd_read = 1'b0, cmd_par = 1'b0, cmd_long = 1'b0;
    logic busy, ser_clk, ser_dout, ser_en, par_strobe, par_rd;
    logic ser_din = 1'b0;
    logic [DW-1:0] value, par_wdata;
    logic [AW-1:0] par_addr;
    logic [DW-1:0] par_rdata = '0;

    int checks = 0;
    int errors = 0;
    logic chk_on = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bbx_reg_access #(
        .AW(AW), .DW(DW), .SCLK_HALF(H), .STROBE_SHORT(SS), .STROBE_LONG(SL)
    ) u_bbx_reg_access (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_reg(cmd_reg),
        .cmd_data(cmd_data), .cmd_read(cmd_read), .cmd_par(cmd_par),
        .cmd_long(cmd_long), .busy(busy), .value(value), .ser_clk(ser_clk),
        .ser_dout(ser_dout), .ser_en(ser_en), .ser_din(ser_din),
        .par_strobe(par_strobe), .par_rd(par_rd), .par_addr(par_addr),
        .par_wdata(par_wdata), .par_rdata(par_rdata)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: mode 0 idle, 1 serial, 2 parallel
    int m_mode = 0, m_cyc = 0, m_rd = 0, m_reg = 0, m_data = 0, m_long = 0;
    int m_value = 0, m_cap = 0;
    string m_vtag = "R2";

    always @(posedge clk) begin : model
        int bi, ph, w;
        if (!rst_n) begin
            m_mode = 0; m_cyc = 0; m_value = 0; m_cap = 0;
        end else if (m_mode == 0) begin
            if (cmd_valid) begin
                m_mode  = cmd_par ? 2 : 1;
                m_cyc   = 0;
                m_rd    = cmd_read;
                m_reg   = cmd_reg;
                m_data  = cmd_data;
                m_long  = cmd_long;
                m_value = cmd_data;
                m_cap   = 0;
                m_vtag  = "R2";
            end
        end else if (m_mode == 1) begin
            bi = m_cyc / (2 * H);
            ph = m_cyc % (2 * H);
            if (m_rd != 0 && bi > AW && ph == H) m_cap = ((m_cap << 1) | int'(ser_din)) & 8'hFF;
            if (m_cyc == FRAME * 2 * H - 1) begin
                m_mode = 0;
                if (m_rd != 0) begin m_value = m_cap; m_vtag = "R8"; end
            end else m_cyc++;
        end else begin
            w = (m_long != 0) ? SL : SS;
            if (m_cyc == w - 1) begin
                m_mode = 0;
                if (m_rd != 0) begin m_value = int'(par_rdata); m_vtag = "R6"; end
            end else m_cyc++;
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin : compare
        int bi, ph, e_dout;
        logic [FRAME-1:0] frame;
        if (chk_on) begin
            bi = m_cyc / (2 * H);
            ph = m_cyc % (2 * H);
            frame = {m_rd[0], m_reg[AW-1:0], m_data[DW-1:0]};
            e_dout = 0;
            if (m_mode == 1 && !(m_rd != 0 && bi > AW)) e_dout = int'(frame[FRAME-1-bi]);
            chk("R9 busy", int'(busy), int'(m_mode != 0));
            chk((m_mode == 2) ? "R4 ser_en" : "R7 ser_en", int'(ser_en), int'(m_mode == 1));
            chk("R7 ser_clk", int'(ser_clk), int'(m_mode == 1 && ph >= H));
            chk((m_mode == 1 && m_rd != 0 && bi > AW) ? "R8 ser_dout" : "R7 ser_dout",
                int'(ser_dout), e_dout);
            chk((m_mode == 1) ? "R4 par_strobe" : "R5 par_strobe", int'(par_strobe), int'(m_mode == 2));
            chk("R10 par_rd", int'(par_rd), (m_mode == 2) ? m_rd : 0);
            chk("R5 par_addr", int'(par_addr), (m_mode == 2) ? m_reg : 0);
            chk("R5 par_wdata", int'(par_wdata), (m_mode == 2) ? m_data : 0);
            chk(m_vtag, int'(value), m_value);
        end
    end

    // Device-side returned data
    always @(negedge clk) begin
        ser_din   <= 1'($urandom);
        par_rdata <= DW'($urandom);
    end

    task automatic wait_idle();
        for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
    endtask

    task automatic send(input logic rd, input logic [7:0] rg, input logic [7:0] dt,
                        input logic par, input logic lng);
        @(negedge clk);
        cmd_read = rd; cmd_reg = rg; cmd_data = dt; cmd_par = par; cmd_long = lng;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R2 busy after accept", int'(busy), 1);
        wait_idle();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        chk("R1 busy", int'(busy), 0);
        chk("R1 ser_en", int'(ser_en), 0);
        chk("R1 par_strobe", int'(par_strobe), 0);
        chk("R1 value", int'(value), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_on = 1'b1;

        send(1'b0, 8'hA5, 8'h3C, 1'b0, 1'b0);
        chk("R2 serial write value", int'(value), 8'h3C);
        send(1'b1, 8'h5A, 8'h00, 1'b0, 1'b0);
        send(1'b0, 8'h12, 8'h34, 1'b1, 1'b0);
        send(1'b0, 8'h56, 8'h78, 1'b1, 1'b1);
        send(1'b1, 8'h9A, 8'h00, 1'b1, 1'b0);
        send(1'b1, 8'hBC, 8'h00, 1'b1, 1'b1);

        // R3: commands offered during a serial write are dropped
        @(negedge clk);
        cmd_read = 1'b0; cmd_reg = 8'h11; cmd_data = 8'h22; cmd_par = 1'b0; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_read = 1'b1; cmd_reg = 8'h77; cmd_data = 8'hEE; cmd_par = 1'b1;
        repeat (20) @(negedge clk);
        cmd_valid = 1'b0;
        chk("R3 still serial", int'(ser_en), 1);
        wait_idle();
        chk("R3 value kept", int'(value), 8'h22);

        // R9: pending command taken right after a parallel transaction
        @(negedge clk);
        cmd_read = 1'b0; cmd_reg = 8'h33; cmd_data = 8'h44; cmd_par = 1'b1; cmd_long = 1'b0;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_data = 8'h55; cmd_long = 1'b1;
        wait_idle();
        chk("R9 one idle cycle", int'(busy), 0);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R9 restarted", int'(busy), 1);
        chk("R9 new data", int'(value), 8'h55);
        wait_idle();

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule